// File: doc/BRIEF.md
# Page Write Buffer and Word Pointer

This block keeps the word pointer of one serial memory access path and gathers the data bytes of one write burst into a page buffer. The serial bit engine in front of it reports events as single-cycle strobes: a word address has been received, a data byte has arrived, a byte has been sent out, or the bus has stopped. The block answers with the current memory address for the array read path. After a stop that closes a burst carrying data, it raises a one-cycle commit request for the array writer. The request carries the start address, the byte count, a per-offset written mask and the buffered page.

One instance serves any of three address spaces, chosen by `space_i`: a 256-byte bank (code 0), a 512-byte combined space made of two banks (code 1), and a 16-byte configuration space (codes 2 and 3). Write bursts wrap inside one page of `PAGE_BYTES` bytes. Sequential reads wrap at the end of the selected space. A word address received with no data after it only moves the pointer, as in a random read that begins with a dummy write.

If several strobes arrive in one cycle, the address load wins, then the stop, then the data byte, then the read byte.

Top module: `page_addr_unit`

## Requirements
- R1: Out of reset `cur_addr_o` is 0 and `commit_o` is low.
- R2: An address load sets `cur_addr_o` to the loaded address masked to the selected space: low 8 bits for code 0, all 9 bits for code 1, low 4 bits for codes 2 and 3. It also opens a write session with an empty buffer.
- R3: Within an open session, each data byte is stored at page offset `cur_addr_o[3:0]`. The pointer's low 4 bits then increment modulo 16 and bits 8:4 stay unchanged, so a byte written at offset Fh leaves the pointer at offset 0h of the same page.
- R4: A stop in a session holding at least one byte makes `commit_o` high for exactly the next cycle. `commit_addr_o` is then the start address, `commit_count_o` the number of bytes received saturated at 16, and `commit_mask_o` bit k set for each offset k written. `commit_data_o[8k+7:8k]` holds the last byte written at offset k.
- R5: After a commit of fewer than 16 bytes, the pointer stays one past the last byte written, wrapped within the page. After a commit of 16 or more bytes, the pointer returns to the start address.
- R6: A stop in a session with no data bytes, or after the session was closed by a read, produces no commit.
- R7: Each read-byte strobe increments the pointer and wraps to 0 after FFh in code 0, after 1FFh in code 1 (passing from 0FFh to 100h), and after Fh in codes 2 and 3. It also closes the write session.
- R8: Data bytes that arrive with no open session leave the pointer unchanged and lead to no commit at the next stop.
- R9: The commit payload outputs keep their values in every cycle in which `commit_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| space_i | input | 2 | Address space: 0 bank, 1 combined, 2/3 configuration |
| load_i | input | 1 | Word address received strobe |
| load_addr_i | input | 9 | Received word address |
| wr_byte_i | input | 1 | Data byte received strobe |
| wr_data_i | input | 8 | Received data byte |
| rd_byte_i | input | 1 | Byte sent to the master strobe |
| stop_i | input | 1 | Stop condition strobe |
| cur_addr_o | output | 9 | Current memory address |
| commit_o | output | 1 | One-cycle write commit request |
| commit_addr_o | output | 9 | Start address of the committed burst |
| commit_count_o | output | 5 | Bytes received, saturated at 16 |
| commit_mask_o | output | 16 | Written page offsets |
| commit_data_o | output | 128 | Page buffer, offset k in bits 8k+7:8k |

## Verification
Write bursts are tried with one byte at the last page offset, with exactly or more than a full page from a mid-page start, and with random lengths. These patterns separate in-page wrapping from a carry into the upper address bits, and last-write-wins from first-write-wins, and they exercise the pointer restore after a full page. Reads are run across each space's end and across the 0FFh to 100h seam, which exposes a wrap limit that ignores the selected space. Dummy writes, reads that close a session, and data sent with no session open show whether the commit comes only from a real burst. A long random mix of loads, bytes, reads and stops in all spaces is compared against a bench model after every event.

// File: rtl/pau_pkg.sv
package pau_pkg;
  typedef enum logic [1:0] {
    SP_BANK = 2'd0,
    SP_COMB = 2'd1,
    SP_CFG  = 2'd2,
    SP_CFGX = 2'd3
  } space_e;
endpackage

// File: rtl/pau_ptr.sv
module pau_ptr #(
  parameter int ADDR_W = 9,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lim_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              restore_i,
  input  logic [ADDR_W-1:0] restore_addr_i,
  input  logic              page_step_i,
  input  logic              seq_step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;

  // Priority: load, restore at commit, in-page step, sequential step
  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = load_i | restore_i | page_step_i | seq_step_i;
    if (load_i) begin
      ptr_d = load_addr_i;
    end else if (restore_i) begin
      ptr_d = restore_addr_i;
    end else if (page_step_i) begin
      ptr_d = {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + OFF_W'(1)};
    end else if (seq_step_i) begin
      ptr_d = (ptr_q + ADDR_W'(1)) & lim_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/pau_page_buf.sv
module pau_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         wr_i,
  input  logic [OFF_W-1:0]             off_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [PAGE_BYTES-1:0]        mask_o,
  output logic [CNT_W-1:0]             count_o,
  output logic [PAGE_BYTES*DATA_W-1:0] data_o
);
  logic [PAGE_BYTES-1:0] mask_q, mask_d, sel;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  meta_en;

  assign sel     = wr_i ? (PAGE_BYTES'(1) << off_i) : '0;
  assign meta_en = clr_i | wr_i;

  always_comb begin
    if (clr_i) begin
      mask_d = '0;
      cnt_d  = '0;
    end else begin
      mask_d = mask_q | sel;
      cnt_d  = (cnt_q == CNT_W'(PAGE_BYTES)) ? cnt_q : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (meta_en) begin
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q <= '0;
      else if (sel[g]) slot_q <= data_i;
    end
    assign data_o[g*DATA_W +: DATA_W] = slot_q;
  end

  assign mask_o  = mask_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/pau_commit.sv
module pau_commit #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fire_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [CNT_W-1:0]             count_i,
  input  logic [PAGE_BYTES-1:0]        mask_i,
  input  logic [PAGE_BYTES*DATA_W-1:0] data_i,
  output logic                         valid_o,
  output logic [ADDR_W-1:0]            addr_o,
  output logic [CNT_W-1:0]             count_o,
  output logic [PAGE_BYTES-1:0]        mask_o,
  output logic [PAGE_BYTES*DATA_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= fire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      count_o <= '0;
      mask_o  <= '0;
      data_o  <= '0;
    end else if (fire_i) begin
      addr_o  <= addr_i;
      count_o <= count_i;
      mask_o  <= mask_i;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/page_addr_unit.sv
module page_addr_unit #(
  parameter int BANK_AW    = 8,
  parameter int CFG_AW     = 4,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int ADDR_W    = BANK_AW + 1,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   space_i,
  input  logic                         load_i,
  input  logic [ADDR_W-1:0]            load_addr_i,
  input  logic                         wr_byte_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         rd_byte_i,
  input  logic                         stop_i,
  output logic [ADDR_W-1:0]            cur_addr_o,
  output logic                         commit_o,
  output logic [ADDR_W-1:0]            commit_addr_o,
  output logic [CNT_W-1:0]             commit_count_o,
  output logic [PAGE_BYTES-1:0]        commit_mask_o,
  output logic [PAGE_BYTES*DATA_W-1:0] commit_data_o
);
  import pau_pkg::*;

  space_e                       space;
  logic [ADDR_W-1:0]            lim, load_m, start_q;
  logic                         sess_q, sess_d, sess_en;
  logic                         wr_ok, rd_step, stop_ev, fire, full;
  logic [PAGE_BYTES-1:0]        buf_mask;
  logic [CNT_W-1:0]             buf_cnt;
  logic [PAGE_BYTES*DATA_W-1:0] buf_data;

  assign space = space_e'(space_i);

  // Wrap limit of the selected space
  always_comb begin
    case (space)
      SP_BANK: lim = ADDR_W'({BANK_AW{1'b1}});
      SP_COMB: lim = '1;
      default: lim = ADDR_W'({CFG_AW{1'b1}});
    endcase
  end

  assign load_m  = load_addr_i & lim;
  assign stop_ev = stop_i & ~load_i;
  assign wr_ok   = wr_byte_i & sess_q & ~load_i & ~stop_i;
  assign rd_step = rd_byte_i & ~load_i & ~stop_i & ~wr_byte_i;
  assign fire    = stop_ev & sess_q & (buf_cnt != '0);
  assign full    = (buf_cnt == CNT_W'(PAGE_BYTES));

  // Write session: opened by an address load, closed by stop or read
  always_comb begin
    sess_en = load_i | stop_ev | rd_step;
    sess_d  = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sess_q <= 1'b0;
    else if (sess_en) sess_q <= sess_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      start_q <= '0;
    else if (load_i) start_q <= load_m;
  end

  pau_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk            (clk),
    .rst_n          (rst_n),
    .lim_i          (lim),
    .load_i         (load_i),
    .load_addr_i    (load_m),
    .restore_i      (fire & full),
    .restore_addr_i (start_q),
    .page_step_i    (wr_ok),
    .seq_step_i     (rd_step),
    .ptr_o          (cur_addr_o)
  );

  pau_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (load_i),
    .wr_i    (wr_ok),
    .off_i   (cur_addr_o[OFF_W-1:0]),
    .data_i  (wr_data_i),
    .mask_o  (buf_mask),
    .count_o (buf_cnt),
    .data_o  (buf_data)
  );

  pau_commit #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire),
    .addr_i  (start_q),
    .count_i (buf_cnt),
    .mask_i  (buf_mask),
    .data_i  (buf_data),
    .valid_o (commit_o),
    .addr_o  (commit_addr_o),
    .count_o (commit_count_o),
    .mask_o  (commit_mask_o),
    .data_o  (commit_data_o)
  );
endmodule

// File: rtl/pau_checker.sv
module pau_checker #(
  parameter int ADDR_W     = 9,
  parameter int CFG_AW     = 4,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [1:0]                   space_i,
  input logic                         wr_ok,
  input logic                         rd_step,
  input logic                         fire,
  input logic                         full,
  input logic [ADDR_W-1:0]            start_q,
  input logic [ADDR_W-1:0]            cur_addr_o,
  input logic                         commit_o,
  input logic [ADDR_W-1:0]            commit_addr_o,
  input logic [CNT_W-1:0]             commit_count_o,
  input logic [PAGE_BYTES-1:0]        commit_mask_o,
  input logic [PAGE_BYTES*DATA_W-1:0] commit_data_o
);
  p_page_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (cur_addr_o[ADDR_W-1:OFF_W] == $past(cur_addr_o[ADDR_W-1:OFF_W])) &&
              (cur_addr_o[OFF_W-1:0] == OFF_W'($past(cur_addr_o[OFF_W-1:0]) + OFF_W'(1))));

  p_commit_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> commit_o && (commit_addr_o == $past(start_q)));

  p_commit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  p_full_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && full) |=> (cur_addr_o == $past(start_q)));

  p_no_empty_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (commit_count_o != '0) && (commit_mask_o != '0));

  p_cfg_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && space_i[1]) |=> (cur_addr_o[ADDR_W-1:CFG_AW] == '0));

  p_payload_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |-> $stable(commit_addr_o) && $stable(commit_count_o) &&
                  $stable(commit_mask_o) && $stable(commit_data_o));
endmodule

bind page_addr_unit pau_checker #(
  .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .space_i        (space_i),
  .wr_ok          (wr_ok),
  .rd_step        (rd_step),
  .fire           (fire),
  .full           (full),
  .start_q        (start_q),
  .cur_addr_o     (cur_addr_o),
  .commit_o       (commit_o),
  .commit_addr_o  (commit_addr_o),
  .commit_count_o (commit_count_o),
  .commit_mask_o  (commit_mask_o),
  .commit_data_o  (commit_data_o)
);

// File: tb/page_addr_unit_bench.sv
`timescale 1ns/1ps
module page_addr_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   space;
  logic         load, wr, rd, stop;
  logic [8:0]   laddr;
  logic [7:0]   wdata;
  logic [8:0]   cur_addr, c_addr;
  logic         c_vld;
  logic [4:0]   c_cnt;
  logic [15:0]  c_mask;
  logic [127:0] c_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // model state
  logic [8:0]  m_ptr, m_start;
  bit          m_sess;
  logic [7:0]  m_buf [16];
  logic [15:0] m_mask;
  int          m_cnt;

  always #4 clk = ~clk;

  page_addr_unit u_page_addr_unit (
    .clk(clk), .rst_n(rst_n), .space_i(space), .load_i(load), .load_addr_i(laddr),
    .wr_byte_i(wr), .wr_data_i(wdata), .rd_byte_i(rd), .stop_i(stop),
    .cur_addr_o(cur_addr), .commit_o(c_vld), .commit_addr_o(c_addr),
    .commit_count_o(c_cnt), .commit_mask_o(c_mask), .commit_data_o(c_data));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] lim_of(input logic [1:0] sp);
    return (sp == 2'd0) ? 9'h0FF : (sp == 2'd1) ? 9'h1FF : 9'h00F;
  endfunction

  function automatic logic [8:0] page_step(input logic [8:0] a);
    return {a[8:4], a[3:0] + 4'd1};
  endfunction

  task automatic op_load(input logic [1:0] sp, input logic [8:0] a);
    @(negedge clk); space = sp; laddr = a; load = 1'b1;
    @(negedge clk); load = 1'b0;
    m_ptr = a & lim_of(sp); m_start = m_ptr; m_sess = 1'b1; m_mask = '0; m_cnt = 0;
    chk("R2", "load pointer", cur_addr, m_ptr);
  endtask

  task automatic op_wr(input logic [7:0] d);
    @(negedge clk); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (m_sess) begin
      m_buf[m_ptr[3:0]] = d; m_mask[m_ptr[3:0]] = 1'b1;
      if (m_cnt < 16) m_cnt++;
      m_ptr = page_step(m_ptr);
      chk("R3", "page step pointer", cur_addr, m_ptr);
    end else begin
      chk("R8", "pointer after stray byte", cur_addr, m_ptr);
    end
  endtask

  task automatic op_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    m_ptr = (m_ptr + 9'd1) & lim_of(space); m_sess = 1'b0;
    chk("R7", "read pointer", cur_addr, m_ptr);
  endtask

  task automatic op_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    if (m_sess && m_cnt > 0) begin
      chk("R4", "commit flag", c_vld, 1);
      chk("R4", "commit addr", c_addr, m_start);
      chk("R4", "commit count", c_cnt, m_cnt);
      chk("R4", "commit mask", c_mask, m_mask);
      for (int k = 0; k < 16; k++)
        if (m_mask[k]) chk("R4", "commit byte", c_data[8*k +: 8], m_buf[k]);
      if (m_cnt == 16) m_ptr = m_start;
      chk("R5", "pointer after commit", cur_addr, m_ptr);
    end else begin
      chk("R6", "no commit", c_vld, 0);
    end
    m_sess = 1'b0;
    @(negedge clk);
    chk("R4", "commit single cycle", c_vld, 0);
  endtask

  initial begin
    logic [8:0]   s_addr;
    logic [15:0]  s_mask;
    logic [127:0] s_data;
    void'($urandom(32'h5EED_0413));
    rst_n = 1'b0; space = 2'd0; load = 1'b0; wr = 1'b0; rd = 1'b0; stop = 1'b0;
    laddr = '0; wdata = '0;
    m_ptr = '0; m_start = '0; m_sess = 1'b0; m_mask = '0; m_cnt = 0;
    for (int k = 0; k < 16; k++) m_buf[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset pointer", cur_addr, 0);
    chk("R1", "reset commit", c_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 masking per space
    op_load(2'd0, 9'h1F3);
    op_load(2'd2, 9'h1A7);
    op_load(2'd1, 9'h1A7);
    // R3/R5 byte at last page offset
    op_load(2'd1, 9'h13F);
    op_wr(8'h5A);
    chk("R3", "wrap to page start", cur_addr, 9'h130);
    op_stop();
    // R4/R5 overfull page, last write wins
    op_load(2'd0, 9'h024);
    for (int i = 0; i < 17; i++) op_wr(8'(8'h10 + i));
    op_stop();
    chk("R5", "restored to start", cur_addr, 9'h024);
    // R6 dummy writes
    op_load(2'd0, 9'h050);
    op_stop();
    op_load(2'd0, 9'h060);
    op_rd();
    op_stop();
    // R8 stray bytes
    op_wr(8'h33);
    op_wr(8'h44);
    op_stop();
    // R7 wrap limits
    op_load(2'd1, 9'h0FE);
    op_rd(); op_rd();
    chk("R7", "combined seam", cur_addr, 9'h100);
    op_load(2'd1, 9'h1FF); op_rd();
    op_load(2'd0, 9'h0FF); op_rd();
    op_load(2'd2, 9'h00F); op_rd();
    // R9 payload hold
    op_load(2'd0, 9'h0A2);
    op_wr(8'hC3); op_wr(8'h3C);
    op_stop();
    s_addr = c_addr; s_mask = c_mask; s_data = c_data;
    op_rd(); op_load(2'd1, 9'h111); op_wr(8'h77); op_rd(); op_stop();
    chk("R9", "held addr", c_addr, s_addr);
    chk("R9", "held mask", c_mask, s_mask);
    chk("R9", "held data low", s_data[63:0] == c_data[63:0], 1);

    // random mix
    for (int n = 0; n < 700; n++) begin
      int unsigned pick;
      pick = $urandom_range(0, 99);
      if (pick < 12)      op_load(2'($urandom_range(0, 3)), 9'($urandom));
      else if (pick < 62) op_wr(8'($urandom));
      else if (pick < 82) op_rd();
      else                op_stop();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule